// File: doc/BRIEF.md
# Dual-Channel Wiper Register Bank

This block keeps the digital state of a two-channel trimming element: one 6-bit wiper counter per channel, plus a small bank of data registers per channel that stand in for nonvolatile storage. A serial front end decodes the host traffic and hands the block one command per cycle. The block answers at once with an acknowledge, and the front end forwards that acknowledge to the host. Reads return one cycle later.

Writing a wiper or loading it from a data register acts like a plain register write: the wiper changes on the next clock edge. Stepping moves a wiper by one count and stops at the ends of its range. Anything that writes into a data register models a slow nonvolatile write. This covers a host write and a copy of the live wiper value. A cycle counter keeps the bank busy for a programmed time, and the stored value appears when that time ends. While the bank is busy, every command is refused. Copies between wipers and data registers can address one channel, or both channels at once at the same register index.

Top module: `wiper_regbank`

## Requirements
- R1: After reset, both wipers and every data register read 0, `busy_o` is 0 and `rd_valid_o` is 0.
- R2: An accepted wiper write (`cmd_op_i` = 1) sets the wiper of channel `cmd_chan_i` to `cmd_wdata_i` on the next edge, and `busy_o` does not rise.
- R3: An accepted step (`cmd_op_i` = 3) moves the selected wiper by one: up when `cmd_up_i` is 1 and down when it is 0. It holds at 63 going up and at 0 going down.
- R4: One cycle after an accepted wiper read (`cmd_op_i` = 2) or data read (`cmd_op_i` = 4), `rd_valid_o` is 1 for one cycle. `rd_data_o` then holds the selected wiper, or data register `cmd_reg_i` of the selected channel.
- R5: An accepted store (`cmd_op_i` = 7, `cmd_all_i` = 0) captures the selected wiper. It holds `busy_o` high for exactly NV_CYCLES cycles, then writes the captured value to data register `cmd_reg_i` of that channel.
- R6: A store with `cmd_all_i` = 1 does the same for every channel at once, all at register index `cmd_reg_i`, and ignores `cmd_chan_i`.
- R7: An accepted load (`cmd_op_i` = 6) copies data register `cmd_reg_i` into the wiper on the next edge. It acts on the selected channel, or on every channel when `cmd_all_i` = 1.
- R8: An accepted data write (`cmd_op_i` = 5) stores `cmd_wdata_i` into register `cmd_reg_i` of the selected channel. It has the same busy time and end-of-busy update as R5.
- R9: While `busy_o` is 1, `cmd_ack_o` is 0 and a presented command changes no wiper, no register and no read output.
- R10: A command other than a load or store with `cmd_all_i` = 1 is refused when `cmd_chan_i` names a channel that does not exist (2 or 3 with two channels). Refused means `cmd_ack_o` is 0 and nothing changes.
- R11: `cmd_ack_o` is combinational and is 1 exactly when `cmd_valid_i` is 1 and the command is accepted. A no-op (`cmd_op_i` = 0) is acknowledged under the same rules and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | A command is presented this cycle |
| cmd_op_i | input | 3 | Operation code: 0 none, 1 write wiper, 2 read wiper, 3 step, 4 read data, 5 write data, 6 load, 7 store |
| cmd_chan_i | input | SEL_W (2) | Channel select |
| cmd_reg_i | input | RSEL_W (2) | Data register select |
| cmd_all_i | input | 1 | Load or store acts on every channel |
| cmd_up_i | input | 1 | Step direction, 1 = up |
| cmd_wdata_i | input | WW (6) | Write value |
| cmd_ack_o | output | 1 | Command accepted this cycle |
| busy_o | output | 1 | Nonvolatile write in progress |
| rd_valid_o | output | 1 | Read result valid |
| rd_data_o | output | WW (6) | Read result |
| wiper_o | output | NCH*WW (12) | Wiper values, channel c at bits c*WW and up |

## Verification
The bench builds the block with NV_CYCLES set to 5 and keeps the default 6-bit wiper, two channels and four registers per channel. A short busy window lets thousands of random cycles pass through many store and data-write windows. This puts in reach the refusals during busy, the commit edge and back-to-back nonvolatile operations. The 6-bit width means that directed writes of 63 and 0 followed by steps reach both saturation ends. The unused channel codes 2 and 3 test refusal of a missing channel.

// File: rtl/wrb_pkg.sv
package wrb_pkg;
   typedef enum logic [2:0] {
      OP_NOP      = 3'd0,
      OP_WR_WIPER = 3'd1,
      OP_RD_WIPER = 3'd2,
      OP_STEP     = 3'd3,
      OP_RD_DATA  = 3'd4,
      OP_WR_DATA  = 3'd5,
      OP_LOAD     = 3'd6,
      OP_STORE    = 3'd7
   } wrb_op_e;

   function automatic logic op_is_nv(input wrb_op_e op);
      return (op == OP_WR_DATA) || (op == OP_STORE);
   endfunction

   function automatic logic op_may_span(input wrb_op_e op);
      return (op == OP_LOAD) || (op == OP_STORE);
   endfunction
endpackage

// File: rtl/wrb_stepper.sv
module wrb_stepper #(
   parameter int WW       = 6,
   parameter bit SATURATE = 1'b1
) (
   input  logic [WW-1:0] cur_i,
   input  logic          up_i,
   output logic [WW-1:0] nxt_o
);
   localparam logic [WW-1:0] TOP = {WW{1'b1}};
   localparam logic [WW-1:0] BOT = '0;
   localparam logic [WW-1:0] ONE = WW'(1);

   generate
      if (SATURATE) begin : g_sat
         always_comb begin
            if (up_i) nxt_o = (cur_i == TOP) ? TOP : cur_i + ONE;
            else      nxt_o = (cur_i == BOT) ? BOT : cur_i - ONE;
         end
      end else begin : g_wrap
         always_comb begin
            if (up_i) nxt_o = cur_i + ONE;
            else      nxt_o = cur_i - ONE;
         end
      end
   endgenerate
endmodule

// File: rtl/wrb_nv_timer.sv
module wrb_nv_timer #(
   parameter int NV_CYCLES = 40
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o,
   output logic done_o
);
   localparam int CW = $clog2(NV_CYCLES + 1);
   localparam logic [CW-1:0] LOADV = CW'(NV_CYCLES);
   localparam logic [CW-1:0] ONE   = CW'(1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (cnt_q != '0)    cnt_q <= cnt_q - ONE;
      else if (start_i)        cnt_q <= LOADV;
   end

   assign busy_o = (cnt_q != '0);
   assign done_o = (cnt_q == ONE);
endmodule

// File: rtl/wrb_channel.sv
module wrb_channel #(
   parameter int WW       = 6,
   parameter int RSEL_W   = 2,
   parameter bit SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [WW-1:0]     wr_val_i,
   input  logic              step_en_i,
   input  logic              step_up_i,
   input  logic              load_en_i,
   input  logic [RSEL_W-1:0] load_idx_i,
   input  logic              commit_en_i,
   input  logic [RSEL_W-1:0] commit_idx_i,
   input  logic [WW-1:0]     commit_val_i,
   input  logic [RSEL_W-1:0] rd_idx_i,
   output logic [WW-1:0]     rd_val_o,
   output logic [WW-1:0]     wiper_o
);
   localparam int NREG = 1 << RSEL_W;

   logic [WW-1:0] wiper_q;
   logic [WW-1:0] stepped;
   logic [WW-1:0] dreg_q [NREG];

   wrb_stepper #(.WW(WW), .SATURATE(SATURATE)) u_step (
      .cur_i (wiper_q),
      .up_i  (step_up_i),
      .nxt_o (stepped)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         wiper_q <= '0;
      else if (wr_en_i)   wiper_q <= wr_val_i;
      else if (step_en_i) wiper_q <= stepped;
      else if (load_en_i) wiper_q <= dreg_q[load_idx_i];
   end

   generate
      for (genvar r = 0; r < NREG; r++) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               dreg_q[r] <= '0;
            else if (commit_en_i && (commit_idx_i == RSEL_W'(r)))
               dreg_q[r] <= commit_val_i;
         end
      end
   endgenerate

   assign rd_val_o = dreg_q[rd_idx_i];
   assign wiper_o  = wiper_q;
endmodule

// File: rtl/wiper_regbank.sv
module wiper_regbank #(
   parameter int WW        = 6,
   parameter int NCH       = 2,
   parameter int SEL_W     = 2,
   parameter int RSEL_W    = 2,
   parameter int NV_CYCLES = 40,
   parameter bit SATURATE  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid_i,
   input  logic [2:0]        cmd_op_i,
   input  logic [SEL_W-1:0]  cmd_chan_i,
   input  logic [RSEL_W-1:0] cmd_reg_i,
   input  logic              cmd_all_i,
   input  logic              cmd_up_i,
   input  logic [WW-1:0]     cmd_wdata_i,
   output logic              cmd_ack_o,
   output logic              busy_o,
   output logic              rd_valid_o,
   output logic [WW-1:0]     rd_data_o,
   output logic [NCH*WW-1:0] wiper_o
);
   import wrb_pkg::*;

   generate
      if (WW < 2)                  begin : g_bad_ww  $error("WW must be at least 2");           end
      if (NCH < 1)                 begin : g_bad_nch $error("NCH must be at least 1");          end
      if (NCH > (1 << SEL_W))      begin : g_bad_sel $error("SEL_W too narrow for NCH");        end
      if (RSEL_W < 1)              begin : g_bad_rs  $error("RSEL_W must be at least 1");       end
      if (NV_CYCLES < 1)           begin : g_bad_nv  $error("NV_CYCLES must be at least 1");    end
   endgenerate

   wrb_op_e op;
   assign op = wrb_op_e'(cmd_op_i);

   logic [NCH-1:0] chan_hit;
   logic           chan_ok;
   logic           span_all;
   logic           accept;
   logic           nv_busy;
   logic           nv_done;

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_hit
         assign chan_hit[c] = (cmd_chan_i == SEL_W'(c));
      end
   endgenerate

   assign chan_ok   = |chan_hit;
   assign span_all  = cmd_all_i && op_may_span(op);
   assign accept    = cmd_valid_i && !nv_busy && (span_all || chan_ok);
   assign cmd_ack_o = accept;
   assign busy_o    = nv_busy;

   wrb_nv_timer #(.NV_CYCLES(NV_CYCLES)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (accept && op_is_nv(op)),
      .busy_o  (nv_busy),
      .done_o  (nv_done)
   );

   logic [WW-1:0]     wip    [NCH];
   logic [WW-1:0]     dval   [NCH];
   logic [NCH-1:0]    tgt;
   logic [NCH-1:0]    pend_mask_q;
   logic [RSEL_W-1:0] pend_idx_q;
   logic [WW-1:0]     pend_val_q [NCH];

   assign tgt = span_all ? {NCH{1'b1}} : chan_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_mask_q <= '0;
         pend_idx_q  <= '0;
      end else if (accept && op_is_nv(op)) begin
         pend_mask_q <= tgt;
         pend_idx_q  <= cmd_reg_i;
      end
   end

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               pend_val_q[c] <= '0;
            else if (accept && (op == OP_STORE))
               pend_val_q[c] <= wip[c];
            else if (accept && (op == OP_WR_DATA))
               pend_val_q[c] <= cmd_wdata_i;
         end

         wrb_channel #(.WW(WW), .RSEL_W(RSEL_W), .SATURATE(SATURATE)) u_chan (
            .clk          (clk),
            .rst_n        (rst_n),
            .wr_en_i      (accept && (op == OP_WR_WIPER) && tgt[c]),
            .wr_val_i     (cmd_wdata_i),
            .step_en_i    (accept && (op == OP_STEP) && tgt[c]),
            .step_up_i    (cmd_up_i),
            .load_en_i    (accept && (op == OP_LOAD) && tgt[c]),
            .load_idx_i   (cmd_reg_i),
            .commit_en_i  (nv_done && pend_mask_q[c]),
            .commit_idx_i (pend_idx_q),
            .commit_val_i (pend_val_q[c]),
            .rd_idx_i     (cmd_reg_i),
            .rd_val_o     (dval[c]),
            .wiper_o      (wip[c])
         );

         assign wiper_o[c*WW +: WW] = wip[c];
      end
   endgenerate

   logic [WW-1:0] rd_mux;
   always_comb begin
      rd_mux = '0;
      for (int c = 0; c < NCH; c++) begin
         if (chan_hit[c]) rd_mux = (op == OP_RD_WIPER) ? wip[c] : dval[c];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid_o <= 1'b0;
         rd_data_o  <= '0;
      end else begin
         rd_valid_o <= accept && ((op == OP_RD_WIPER) || (op == OP_RD_DATA));
         if (accept && ((op == OP_RD_WIPER) || (op == OP_RD_DATA)))
            rd_data_o <= rd_mux;
      end
   end
endmodule

// File: rtl/wiper_regbank_chk.sv
module wiper_regbank_chk #(
   parameter int WW        = 6,
   parameter int NCH       = 2,
   parameter int SEL_W     = 2,
   parameter int RSEL_W    = 2,
   parameter int NV_CYCLES = 40,
   parameter bit SATURATE  = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid_i,
   input logic [2:0]        cmd_op_i,
   input logic [SEL_W-1:0]  cmd_chan_i,
   input logic              cmd_all_i,
   input logic              cmd_up_i,
   input logic [WW-1:0]     cmd_wdata_i,
   input logic              cmd_ack_o,
   input logic              busy_o,
   input logic              rd_valid_o,
   input logic [NCH*WW-1:0] wiper_o
);
   localparam logic [WW-1:0] TOP = {WW{1'b1}};

   int unsigned busy_len;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      busy_len <= 0;
      else if (busy_o) busy_len <= busy_len + 1;
      else             busy_len <= 0;
   end

   p_busy_refuse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !cmd_ack_o);

   p_ack_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ack_o |-> cmd_valid_i);

   p_bad_chan_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!(cmd_all_i && cmd_op_i[2:1] == 2'b11) && (int'(cmd_chan_i) >= NCH)) |-> !cmd_ack_o);

   p_rd_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid_o |-> $past(cmd_ack_o && (cmd_op_i == 3'd2 || cmd_op_i == 3'd4)));

   p_busy_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(cmd_ack_o && (cmd_op_i == 3'd5 || cmd_op_i == 3'd7)));

   p_busy_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> (busy_len == NV_CYCLES));

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_c
         p_wr_wiper_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_ack_o && cmd_op_i == 3'd1 && int'(cmd_chan_i) == c)
            |=> (wiper_o[c*WW +: WW] == $past(cmd_wdata_i)));

         p_hold_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
            busy_o |=> $stable(wiper_o[c*WW +: WW]));

         if (SATURATE) begin : g_sat
            p_top_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
               (cmd_ack_o && cmd_op_i == 3'd3 && int'(cmd_chan_i) == c && cmd_up_i
                && wiper_o[c*WW +: WW] == TOP) |=> (wiper_o[c*WW +: WW] == TOP));
            p_bot_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
               (cmd_ack_o && cmd_op_i == 3'd3 && int'(cmd_chan_i) == c && !cmd_up_i
                && wiper_o[c*WW +: WW] == '0) |=> (wiper_o[c*WW +: WW] == '0));
         end
      end
   endgenerate
endmodule

bind wiper_regbank wiper_regbank_chk #(
   .WW(WW), .NCH(NCH), .SEL_W(SEL_W), .RSEL_W(RSEL_W),
   .NV_CYCLES(NV_CYCLES), .SATURATE(SATURATE)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cmd_valid_i (cmd_valid_i),
   .cmd_op_i    (cmd_op_i),
   .cmd_chan_i  (cmd_chan_i),
   .cmd_all_i   (cmd_all_i),
   .cmd_up_i    (cmd_up_i),
   .cmd_wdata_i (cmd_wdata_i),
   .cmd_ack_o   (cmd_ack_o),
   .busy_o      (busy_o),
   .rd_valid_o  (rd_valid_o),
   .wiper_o     (wiper_o)
);

// File: tb/wiper_regbank_tb.sv
`timescale 1ns/1ps
module wiper_regbank_tb;
   localparam int WW = 6;
   localparam int NCH = 2;
   localparam int NV = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_valid_i = 1'b0;
   logic [2:0] cmd_op_i = '0;
   logic [1:0] cmd_chan_i = '0;
   logic [1:0] cmd_reg_i = '0;
   logic cmd_all_i = 1'b0;
   logic cmd_up_i = 1'b0;
   logic [WW-1:0] cmd_wdata_i = '0;
   logic cmd_ack_o, busy_o, rd_valid_o;
   logic [WW-1:0] rd_data_o;
   logic [NCH*WW-1:0] wiper_o;

   always #4 clk = ~clk;

   wiper_regbank #(.NV_CYCLES(NV)) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i),
      .cmd_chan_i(cmd_chan_i), .cmd_reg_i(cmd_reg_i), .cmd_all_i(cmd_all_i),
      .cmd_up_i(cmd_up_i), .cmd_wdata_i(cmd_wdata_i), .cmd_ack_o(cmd_ack_o),
      .busy_o(busy_o), .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .wiper_o(wiper_o)
   );

   int tests = 0;
   int fails = 0;

   int m_w [2];
   int m_d [2][4];
   int m_cnt, m_pidx, m_rdd;
   int m_pmask [2];
   int m_pval [2];
   bit m_rdv;

   task automatic chk(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int step_exp(input int v, input bit up);
      if (up) return (v == 63) ? 63 : v + 1;
      return (v == 0) ? 0 : v - 1;
   endfunction

   function automatic bit ack_exp(input bit vld, input int op, input int ch, input bit all);
      return vld && (m_cnt == 0) && ((all && (op == 6 || op == 7)) || ch < NCH);
   endfunction

   task automatic check_state();
      for (int c = 0; c < NCH; c++)
         chk($sformatf("R2 R3 R7 R9 wiper%0d", c), int'(wiper_o[c*WW +: WW]), m_w[c]);
      chk("R5 R8 busy", int'(busy_o), int'(m_cnt != 0));
      chk("R4 rd_valid", int'(rd_valid_o), int'(m_rdv));
      if (m_rdv) chk("R4 rd_data", int'(rd_data_o), m_rdd);
   endtask

   task automatic cyc(input bit vld, input int op, input int ch, input int rg,
                      input bit all, input int dat, input bit up);
      bit a;
      check_state();
      cmd_valid_i = vld; cmd_op_i = 3'(op); cmd_chan_i = 2'(ch); cmd_reg_i = 2'(rg);
      cmd_all_i = all; cmd_wdata_i = 6'(dat); cmd_up_i = up;
      #1;
      a = ack_exp(vld, op, ch, all);
      chk("R9 R10 R11 ack", int'(cmd_ack_o), int'(a));
      m_rdv = 1'b0;
      if (m_cnt != 0) begin
         if (m_cnt == 1)
            for (int c = 0; c < NCH; c++) if (m_pmask[c] != 0) m_d[c][m_pidx] = m_pval[c];
         m_cnt--;
      end else if (a) begin
         case (op)
            1: m_w[ch] = dat;
            2: begin m_rdv = 1'b1; m_rdd = m_w[ch]; end
            3: m_w[ch] = step_exp(m_w[ch], up);
            4: begin m_rdv = 1'b1; m_rdd = m_d[ch][rg]; end
            5: begin
               for (int c = 0; c < NCH; c++) m_pmask[c] = (c == ch);
               m_pval[ch] = dat; m_pidx = rg; m_cnt = NV;
            end
            6: for (int c = 0; c < NCH; c++) if (all || c == ch) m_w[c] = m_d[c][rg];
            7: begin
               for (int c = 0; c < NCH; c++) begin
                  m_pmask[c] = (all || c == ch);
                  m_pval[c] = m_w[c];
               end
               m_pidx = rg; m_cnt = NV;
            end
            default: ;
         endcase
      end
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(1'b0, 0, 0, 0, 1'b0, 0, 1'b0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_0c1a));
      for (int c = 0; c < 2; c++) begin
         m_w[c] = 0; m_pmask[c] = 0; m_pval[c] = 0;
         for (int r = 0; r < 4; r++) m_d[c][r] = 0;
      end
      m_cnt = 0; m_pidx = 0; m_rdv = 0; m_rdd = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state at the ports, then every data register read back
      chk("R1 wiper0", int'(wiper_o[5:0]), 0);
      chk("R1 wiper1", int'(wiper_o[11:6]), 0);
      chk("R1 busy", int'(busy_o), 0);
      chk("R1 rd_valid", int'(rd_valid_o), 0);
      for (int c = 0; c < 2; c++)
         for (int r = 0; r < 4; r++) cyc(1'b1, 4, c, r, 1'b0, 0, 1'b0);
      // R2 write, R3 saturation at both ends and plain steps
      cyc(1'b1, 1, 0, 0, 1'b0, 63, 1'b0);
      cyc(1'b1, 3, 0, 0, 1'b0, 0, 1'b1);
      cyc(1'b1, 3, 0, 0, 1'b0, 0, 1'b0);
      cyc(1'b1, 1, 1, 0, 1'b0, 0, 1'b0);
      cyc(1'b1, 3, 1, 0, 1'b0, 0, 1'b0);
      cyc(1'b1, 3, 1, 0, 1'b0, 0, 1'b1);
      cyc(1'b1, 2, 1, 0, 1'b0, 0, 1'b0);
      // R5 single store, then R9 refusal while busy
      cyc(1'b1, 7, 0, 2, 1'b0, 0, 1'b0);
      cyc(1'b1, 1, 0, 0, 1'b0, 5, 1'b0);
      cyc(1'b1, 4, 0, 2, 1'b0, 0, 1'b0);
      idle(NV);
      cyc(1'b1, 4, 0, 2, 1'b0, 0, 1'b0);
      chk("R5 stored value", int'(m_rdd), 62);
      // R6 global store
      cyc(1'b1, 1, 0, 0, 1'b0, 10, 1'b0);
      cyc(1'b1, 1, 1, 0, 1'b0, 20, 1'b0);
      cyc(1'b1, 7, 3, 1, 1'b1, 0, 1'b0);
      idle(NV);
      cyc(1'b1, 4, 0, 1, 1'b0, 0, 1'b0);
      cyc(1'b1, 4, 1, 1, 1'b0, 0, 1'b0);
      // R8 host data write, R7 single and global load
      cyc(1'b1, 5, 1, 3, 1'b0, 42, 1'b0);
      idle(NV);
      cyc(1'b1, 6, 1, 3, 1'b0, 0, 1'b0);
      cyc(1'b1, 1, 0, 0, 1'b0, 0, 1'b0);
      cyc(1'b1, 1, 1, 0, 1'b0, 0, 1'b0);
      cyc(1'b1, 6, 2, 1, 1'b1, 0, 1'b0);
      // R10 missing channel, R11 no-op
      cyc(1'b1, 1, 2, 0, 1'b0, 33, 1'b0);
      cyc(1'b1, 3, 3, 0, 1'b0, 0, 1'b1);
      cyc(1'b1, 0, 0, 0, 1'b0, 0, 1'b0);
      // constrained random mix
      for (int i = 0; i < 4000; i++) begin
         int ch;
         ch = (($urandom % 8) == 0) ? 2 + int'($urandom % 2) : int'($urandom % 2);
         cyc(($urandom % 5) != 0, int'($urandom % 8), ch, int'($urandom % 4),
             ($urandom % 2) == 1, (($urandom % 4) == 0) ? 63 * int'($urandom % 2) : int'($urandom % 64),
             ($urandom % 2) == 1);
      end
      check_state();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule